// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Deferral

This block decides when a DRAM needs a refresh and tells the memory controller. A free-running interval timer produces one refresh obligation every 7.8 us. At the default 200 MHz clock that is 1560 cycles. Each obligation is added to a pending count. The controller does not have to serve the obligation at once. While it reports itself busy, obligations pile up, and when it goes idle it can issue them back to back. Each refresh it actually issues is acknowledged to this block, which lowers the count.

Two requests leave the block. The normal request is an invitation, offered only while pending work exists and the controller is idle. The urgent request appears once the backlog reaches its hard limit of eight. This limit matches the largest burst the memory accepts, and the 64 ms window in which 8192 refreshes must fall. The urgent request ignores the busy input, so the controller must stop other traffic and refresh. If one more interval expires while the backlog is already full, the obligation cannot be recorded. The count is held at eight and a sticky error output is raised.

Top module: `refresh_sched`

## Requirements
- R1: Reset drives the pending count to 0 and clears the normal request, the urgent request and the error output. It also restarts the interval timer, so the first expiry after reset release lands on the 1560th rising edge.
- R2: Every 1560 clock cycles (CLK_MHZ*INTERVAL_NS/1000) the interval expires once, and the pending count rises by one.
- R3: An acknowledge lowers the pending count by one at the next rising edge. An acknowledge while the count is 0 is ignored, and the count stays 0.
- R4: An expiry and an accepted acknowledge in the same cycle leave the pending count unchanged.
- R5: The normal request is high exactly when the pending count is nonzero and the busy input is low.
- R6: The urgent request is high exactly when the pending count equals 8, whatever the busy input.
- R7: The pending count never exceeds 8. An expiry at a count of 8 with no accepted acknowledge keeps the count at 8 and sets the error output, which then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_busy | input | 1 | High while the controller cannot spare time for a refresh |
| ref_ack | input | 1 | One-cycle pulse for each refresh the controller issued |
| ref_req | output | 1 | Normal refresh request (backlog present, controller idle) |
| ref_urgent | output | 1 | Backlog full; refresh must be issued now |
| pend_cnt | output | CNT_W (4) | Number of refreshes owed |
| pend_err | output | 1 | Sticky flag: an expiry was lost at a full backlog |

## Verification
Two events can fall in the same cycle: the interval expiry and an acknowledge from the controller. Their meeting decides whether the count moves or holds. The bench tracks the timer phase in its behavioural model. It raises the acknowledge in exactly the cycle whose next edge carries an expiry, and expects the count to stay put. The same phase tracking places an expiry on a full backlog, with no acknowledge, to provoke the error. The model is compared with every output on every clock, so any slip in the ordering of increment, decrement and saturation shows at once.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  // Number of clock cycles in one refresh interval.
  function automatic int interval_cycles(input int clk_mhz, input int interval_ns);
    return (clk_mhz * interval_ns) / 1000;
  endfunction

  // Bits needed to hold values 0..max_val.
  function automatic int bits_for(input int max_val);
    int w;
    w = 1;
    while ((1 << w) <= max_val) w++;
    return w;
  endfunction

  // Whether an acknowledge is taken at the given backlog.
  function automatic bit ack_accepted(input int cur, input bit ack);
    return ack && (cur != 0);
  endfunction

  // Whether an expiry is lost because the backlog is already full.
  function automatic bit expiry_lost(input int cur, input int max_pend,
                                     input bit expire, input bit taken);
    return expire && !taken && (cur == max_pend);
  endfunction

  // Next backlog value, given expiry and accepted acknowledge.
  function automatic int next_backlog(input int cur, input int max_pend,
                                      input bit expire, input bit taken);
    int n;
    if (expiry_lost(cur, max_pend, expire, taken)) begin
      n = cur;
    end else begin
      n = cur + (expire ? 1 : 0) - (taken ? 1 : 0);
    end
    return n;
  endfunction

endpackage

// File: rtl/rfs_interval_timer.sv
module rfs_interval_timer #(
  parameter int INTERVAL_CYC = 1560
) (
  input  logic clk,
  input  logic rst_n,
  output logic expire
);
  localparam int TMR_W = rfs_pkg::bits_for(INTERVAL_CYC - 1);
  localparam logic [TMR_W-1:0] LAST = TMR_W'(INTERVAL_CYC - 1);

  logic [TMR_W-1:0] phase_q;

  assign expire = (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (expire) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/rfs_backlog_ctr.sv
module rfs_backlog_ctr #(
  parameter int MAX_PEND = 8,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expire,
  input  logic             ack,
  output logic [CNT_W-1:0] count,
  output logic             ack_taken,
  output logic             lost_evt,
  output logic             err
);
  logic [CNT_W-1:0] count_d;
  int               cur_i;

  always_comb begin
    cur_i     = int'(count);
    ack_taken = rfs_pkg::ack_accepted(cur_i, ack);
    lost_evt  = rfs_pkg::expiry_lost(cur_i, MAX_PEND, expire, ack_taken);
    count_d   = CNT_W'(rfs_pkg::next_backlog(cur_i, MAX_PEND, expire, ack_taken));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      err   <= 1'b0;
    end else begin
      count <= count_d;
      if (lost_evt) err <= 1'b1;
    end
  end
endmodule

// File: rtl/rfs_req_logic.sv
module rfs_req_logic #(
  parameter int MAX_PEND = 8,
  parameter int CNT_W    = 4
) (
  input  logic [CNT_W-1:0] count,
  input  logic             busy,
  output logic             req,
  output logic             urgent
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(MAX_PEND);

  assign req    = (count != '0) && !busy;
  assign urgent = (count == FULL);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int CLK_MHZ     = 200,
  parameter int INTERVAL_NS = 7800,
  parameter int MAX_PEND    = 8,
  parameter int CNT_W       = rfs_pkg::bits_for(MAX_PEND)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_busy,
  input  logic             ref_ack,
  output logic             ref_req,
  output logic             ref_urgent,
  output logic [CNT_W-1:0] pend_cnt,
  output logic             pend_err
);
  localparam int INTERVAL_CYC = rfs_pkg::interval_cycles(CLK_MHZ, INTERVAL_NS);

  // Internal events brought out for the checker.
  logic interval_tick;
  logic ack_taken;
  logic lost_evt;

  rfs_interval_timer #(
    .INTERVAL_CYC(INTERVAL_CYC)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .expire(interval_tick)
  );

  rfs_backlog_ctr #(
    .MAX_PEND(MAX_PEND),
    .CNT_W   (CNT_W)
  ) u_backlog (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire   (interval_tick),
    .ack      (ref_ack),
    .count    (pend_cnt),
    .ack_taken(ack_taken),
    .lost_evt (lost_evt),
    .err      (pend_err)
  );

  rfs_req_logic #(
    .MAX_PEND(MAX_PEND),
    .CNT_W   (CNT_W)
  ) u_req (
    .count (pend_cnt),
    .busy  (ctrl_busy),
    .req   (ref_req),
    .urgent(ref_urgent)
  );
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int MAX_PEND = 8,
  parameter int CNT_W    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_busy,
  input logic             ref_ack,
  input logic             ref_req,
  input logic             ref_urgent,
  input logic [CNT_W-1:0] pend_cnt,
  input logic             pend_err,
  input logic             interval_tick,
  input logic             ack_taken,
  input logic             lost_evt
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(MAX_PEND);

  assert_tick_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    interval_tick && !ref_ack && pend_cnt < FULL |=> pend_cnt == $past(pend_cnt) + 1'b1);

  assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    interval_tick |=> !interval_tick);

  assert_ack_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack && !interval_tick && pend_cnt != '0 |=> pend_cnt == $past(pend_cnt) - 1'b1);

  assert_ack_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack && !interval_tick && pend_cnt == '0 |=> pend_cnt == '0);

  assert_both_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    interval_tick && ack_taken |=> $stable(pend_cnt));

  assert_req_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !ctrl_busy && pend_cnt != '0);

  assert_urgent_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_busy && pend_cnt == FULL |-> ref_urgent);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= FULL);

  assert_lost_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lost_evt |=> pend_err && pend_cnt == FULL);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_err |=> pend_err);
endmodule

bind refresh_sched refresh_sched_chk #(
  .MAX_PEND(MAX_PEND),
  .CNT_W   (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctrl_busy    (ctrl_busy),
  .ref_ack      (ref_ack),
  .ref_req      (ref_req),
  .ref_urgent   (ref_urgent),
  .pend_cnt     (pend_cnt),
  .pend_err     (pend_err),
  .interval_tick(interval_tick),
  .ack_taken    (ack_taken),
  .lost_evt     (lost_evt)
);

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb;
  localparam int IVL  = 1560;
  localparam int FULL = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_busy = 1'b0;
  logic       ref_ack = 1'b0;
  logic       ref_req;
  logic       ref_urgent;
  logic [3:0] pend_cnt;
  logic       pend_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Behavioural reference model.
  int m_phase = 0;
  int m_owed = 0;
  bit m_err = 0;

  refresh_sched u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_busy (ctrl_busy),
    .ref_ack   (ref_ack),
    .ref_req   (ref_req),
    .ref_urgent(ref_urgent),
    .pend_cnt  (pend_cnt),
    .pend_err  (pend_err)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0;
      m_owed  = 0;
      m_err   = 0;
    end else begin
      bit due;
      bit dec;
      due = (m_phase == IVL - 1);
      m_phase = due ? 0 : m_phase + 1;
      dec = ref_ack && (m_owed > 0);
      if (due && !dec && m_owed == FULL) m_err = 1;
      else m_owed = m_owed + (due ? 1 : 0) - (dec ? 1 : 0);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model.
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      check(int'(pend_cnt) == m_owed, "R3 model count", int'(pend_cnt), m_owed);
      check(ref_req == (m_owed != 0 && !ctrl_busy), "R5 model req",
            int'(ref_req), int'(m_owed != 0 && !ctrl_busy));
      check(ref_urgent == (m_owed == FULL), "R6 model urgent",
            int'(ref_urgent), int'(m_owed == FULL));
      check(pend_err == m_err, "R7 model err", int'(pend_err), int'(m_err));
    end
  end

  task automatic cyc(input bit b, input bit a);
    @(negedge clk);
    ctrl_busy = b;
    ref_ack   = a;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ctrl_busy = 1'b0;
    ref_ack = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(pend_cnt == 0 && !ref_req && !ref_urgent && !pend_err, "R1 reset state",
          int'(pend_cnt), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Returns with the cycle whose next edge carries an expiry.
  task automatic reach_due(input bit b);
    while (m_phase != IVL - 1) cyc(b, 1'b0);
  endtask

  initial begin
    int t;
    for (t = 0; t < 190000 && !done; t++) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=0", t);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R2: first expiry exactly on the 1560th edge
    repeat (IVL - 1) cyc(1'b1, 1'b0);
    check(pend_cnt == 0, "R2 before first expiry", int'(pend_cnt), 0);
    cyc(1'b1, 1'b0);
    check(pend_cnt == 1, "R2 first expiry", int'(pend_cnt), 1);
    check(!ref_req, "R5 busy hides req", int'(ref_req), 0);
    repeat (2 * IVL) cyc(1'b1, 1'b0);
    check(pend_cnt == 3, "R2 three expiries", int'(pend_cnt), 3);
    cyc(1'b0, 1'b0);
    check(ref_req, "R5 idle with backlog", int'(ref_req), 1);
    // R3: burst drain
    repeat (3) cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b0);
    check(pend_cnt == 0, "R3 burst drain", int'(pend_cnt), 0);
    check(!ref_req, "R5 no backlog no req", int'(ref_req), 0);
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b0);
    check(pend_cnt == 0, "R3 ack at zero ignored", int'(pend_cnt), 0);
    // R4: expiry and acknowledge together
    reach_due(1'b1);
    cyc(1'b1, 1'b0);
    check(pend_cnt == 1, "R2 expiry to one", int'(pend_cnt), 1);
    reach_due(1'b1);
    ref_ack = 1'b1;
    cyc(1'b1, 1'b0);
    check(pend_cnt == 1, "R4 simultaneous hold", int'(pend_cnt), 1);
    // R6: fill to the limit while busy
    while (m_owed != FULL - 1) cyc(1'b1, 1'b0);
    check(!ref_urgent, "R6 seven not urgent", int'(ref_urgent), 0);
    while (m_owed != FULL) cyc(1'b1, 1'b0);
    check(ref_urgent && !ref_req, "R6 urgent while busy", int'(ref_urgent), 1);
    cyc(1'b0, 1'b0);
    check(ref_urgent && ref_req, "R6 urgent while idle", int'(ref_req), 1);
    // R7: expiry at a full backlog
    reach_due(1'b1);
    cyc(1'b1, 1'b0);
    check(pend_cnt == FULL, "R7 count capped", int'(pend_cnt), FULL);
    check(pend_err, "R7 error raised", int'(pend_err), 1);
    repeat (FULL) cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b0);
    check(pend_cnt == 0 && !ref_urgent, "R3 full drain", int'(pend_cnt), 0);
    check(pend_err, "R7 error sticky", int'(pend_err), 1);
    // R1: reset mid-run restarts the timer
    repeat (100) cyc(1'b1, 1'b0);
    do_reset();
    repeat (IVL - 1) cyc(1'b1, 1'b0);
    check(pend_cnt == 0, "R1 timer restarted", int'(pend_cnt), 0);
    cyc(1'b1, 1'b0);
    check(pend_cnt == 1, "R1 first expiry after reset", int'(pend_cnt), 1);
    check(!pend_err, "R1 error cleared", int'(pend_err), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule